// File: doc/BRIEF.md
# Comparison Strobe Divider with Twin Post-Selectors

This block derives two comparison-rate strobes for a pair of frequency synthesisers from one reference clock. A single programmable base counter divides the reference by a 12-bit integer. Its terminal count then drives two small post-dividers: one sets the main comparison rate and the other the auxiliary rate. Both rates are therefore fixed divisions of one shared base rate. For example, a base division of 297 on a 14.85 MHz reference gives a 50 kHz base. A main selection of four then gives 12.5 kHz, and an auxiliary selection of one keeps the 50 kHz. The same overall main ratio of 1188 could equally be built as 594 with a selection of two, or as 1188 with a selection of one.

The division settings arrive as parallel inputs and may change at any time. The base counter samples the new division value only at its own terminal count. Each post-divider samples its select code only when it issues a strobe. This means a partly elapsed interval is never cut short or stretched. Each output is a registered single-cycle pulse. A synchronous reset clears every counter, so both outputs start phase-aligned.

Top module: `cmpStrobeDivider`

## Requirements
- R1: While `rst` is high, both strobes are low. After `rst` is released, both strobes are high together in the cycle that follows the first rising edge.
- R2: Base terminal counts occur once every NR reference cycles, where NR is the 12-bit value on `nrVal`. With NR = 4095 they are 4095 cycles apart.
- R3: An `nrVal` of 0 or 1 divides by one, so a base terminal count occurs on every reference cycle.
- R4: `nrVal` is sampled only at a base terminal count. A changed value sets the length of the interval that starts there, and the interval already running keeps its old length.
- R5: `mainSel` picks the main post-division: 2'b00 gives 1, 2'b01 gives 4, 2'b10 gives 2, and 2'b11 gives 1. The main strobe fires on the first base terminal count after reset and then on every M-th one, where M is the selected ratio.
- R6: `auxSel` uses the same encoding as `mainSel` and runs independently of it. The auxiliary strobe fires on the first base terminal count and on every A-th one after that.
- R7: A change of select code takes effect at the next strobe of that chain. The ratio is sampled at the moment a strobe is issued.
- R8: Each strobe is one reference cycle wide. It goes high only in the cycle directly after a base terminal count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| nrVal | input | 12 | Base division value (0 and 1 mean divide by one) |
| mainSel | input | 2 | Main post-division select code |
| auxSel | input | 2 | Auxiliary post-division select code |
| mainStrobe | output | 1 | Main comparison strobe, one cycle wide |
| auxStrobe | output | 1 | Auxiliary comparison strobe, one cycle wide |

## Verification
The in-RTL assertions check several rules on every cycle. Each strobe must follow a base terminal count by exactly one cycle, and reset must clear both strobes. The base counter must fire in the first cycle after reset is released, and a division value of 0 or 1 must keep terminal counts back to back. Only the bench's scenarios can show the actual rates. The bench sweeps every select-code pair over small base divisions and a maximum-value division, and checks the spacing of strobes after mid-interval changes to the division value and to the select codes.

// File: rtl/cmpdiv_pkg.sv
package cmpdiv_pkg;

  localparam int NR_W      = 12;
  localparam int SEL_W     = 2;
  localparam int MAX_RATIO = 4;
  localparam int PH_W      = $clog2(MAX_RATIO);
  localparam int N_CHAINS  = 2;

  typedef struct packed {
    logic baseTick;
    logic clearAll;
  } ctlStrobes_t;

  // Post-division ratio minus one for a select code (11 acts as 1).
  function automatic logic [PH_W-1:0] ratioLess1(input logic [SEL_W-1:0] code);
    logic [PH_W-1:0] r;
    case (code)
      2'b01:   r = PH_W'(MAX_RATIO - 1);
      2'b10:   r = PH_W'(1);
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cmpdiv_ctrl.sv
module cmpdiv_ctrl
  import cmpdiv_pkg::*;
#(
  parameter int CNT_W = NR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] nrVal,
  output ctlStrobes_t      ctl
);

  localparam logic [CNT_W-1:0] UNIT = CNT_W'(1);

  logic [CNT_W-1:0] baseCnt;
  logic [CNT_W-1:0] effNr;
  logic             atTerm;

  always_comb begin
    atTerm       = (baseCnt == '0);
    effNr        = (nrVal <= UNIT) ? UNIT : nrVal;
    ctl.baseTick = atTerm;
    ctl.clearAll = rst;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      baseCnt <= '0;
    end else if (atTerm) begin
      baseCnt <= effNr - UNIT;
    end else begin
      baseCnt <= baseCnt - UNIT;
    end
  end

  // R1: the base stage fires in the first cycle after reset release
  a_r1_first_tick: assert property (@(posedge clk)
    ($past(rst) && !rst) |-> ctl.baseTick);

  // R3: a division value of 0 or 1 keeps terminal counts back to back
  a_r3_unity_ratio: assert property (@(posedge clk) disable iff (rst)
    (ctl.baseTick && (nrVal <= UNIT)) |=> ctl.baseTick);

endmodule

// File: rtl/cmpdiv_post.sv
module cmpdiv_post
  import cmpdiv_pkg::*;
#(
  parameter int CHAINS = N_CHAINS
) (
  input  logic                         clk,
  input  ctlStrobes_t                  ctl,
  input  logic [CHAINS-1:0][SEL_W-1:0] selBus,
  output logic [CHAINS-1:0]            strobeBus
);

  for (genvar g = 0; g < CHAINS; g++) begin : gChain
    logic [PH_W-1:0] phase;
    logic            fire;

    always_comb fire = ctl.baseTick && (phase == '0);

    always_ff @(posedge clk) begin
      if (ctl.clearAll) begin
        phase        <= '0;
        strobeBus[g] <= 1'b0;
      end else begin
        strobeBus[g] <= fire;
        if (fire) begin
          phase <= ratioLess1(selBus[g]);
        end else if (ctl.baseTick) begin
          phase <= phase - PH_W'(1);
        end
      end
    end

    // R8: a strobe appears only one cycle after a base terminal count
    a_r8_strobe_after_tick: assert property (@(posedge clk) disable iff (ctl.clearAll)
      strobeBus[g] |-> $past(ctl.baseTick));

    // R1: reset leaves the strobe low
    a_r1_reset_clears: assert property (@(posedge clk)
      $past(ctl.clearAll) |-> !strobeBus[g]);
  end

endmodule

// File: rtl/cmpStrobeDivider.sv
module cmpStrobeDivider
  import cmpdiv_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NR_W-1:0] nrVal,
  input  logic [1:0]      mainSel,
  input  logic [1:0]      auxSel,
  output logic            mainStrobe,
  output logic            auxStrobe
);

  ctlStrobes_t                    ctl;
  logic [N_CHAINS-1:0][SEL_W-1:0] selBus;
  logic [N_CHAINS-1:0]            strobeBus;

  assign selBus[0]  = mainSel;
  assign selBus[1]  = auxSel;
  assign mainStrobe = strobeBus[0];
  assign auxStrobe  = strobeBus[1];

  cmpdiv_ctrl #(.CNT_W(NR_W)) ctrl_i (
    .clk   (clk),
    .rst   (rst),
    .nrVal (nrVal),
    .ctl   (ctl)
  );

  cmpdiv_post #(.CHAINS(N_CHAINS)) post_i (
    .clk       (clk),
    .ctl       (ctl),
    .selBus    (selBus),
    .strobeBus (strobeBus)
  );

endmodule

// File: tb/cmpStrobeDivider_tb.sv
module cmpStrobeDivider_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] nrVal = 12'd1;
  logic [1:0]  mainSel = 2'b00;
  logic [1:0]  auxSel = 2'b00;
  logic        mainStrobe, auxStrobe;
  int          total = 0;
  int          bad = 0;
  bit          ended = 0;

  always #2.5 clk = ~clk;

  cmpStrobeDivider dut_i (
    .clk(clk), .rst(rst), .nrVal(nrVal), .mainSel(mainSel),
    .auxSel(auxSel), .mainStrobe(mainStrobe), .auxStrobe(auxStrobe)
  );

  function automatic int ratioOf(input logic [1:0] c);
    case (c)
      2'b01:   return 4;
      2'b10:   return 2;
      default: return 1;
    endcase
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Apply a configuration under reset, check R1 during reset, then release.
  task automatic startCfg(input int nr, input logic [1:0] sm, input logic [1:0] sa);
    @(negedge clk);
    rst = 1'b1; nrVal = 12'(nr); mainSel = sm; auxSel = sa;
    repeat (2) @(negedge clk);
    check("R1 main in reset", mainStrobe, 1'b0);
    check("R1 aux in reset", auxStrobe, 1'b0);
    rst = 1'b0;
  endtask

  // Static configuration: compare every cycle against the arithmetic model.
  task automatic runCfg(input int nr, input logic [1:0] sm, input logic [1:0] sa, input int cycles);
    int effN, m, a;
    effN = (nr <= 1) ? 1 : nr;
    m = ratioOf(sm);
    a = ratioOf(sa);
    startCfg(nr, sm, sa);
    for (int p = 1; p <= cycles; p++) begin
      int  k;
      bit  onTick;
      @(posedge clk); #1;
      k = (p - 1) / effN;
      onTick = ((p - 1) % effN) == 0;
      if (p == 1) begin
        check("R1 main aligned", mainStrobe, 1'b1);
        check("R1 aux aligned", auxStrobe, 1'b1);
      end
      if (nr <= 1) begin
        check("R3 main unity", mainStrobe, logic'((k % m) == 0));
        check("R3 aux unity", auxStrobe, logic'((k % a) == 0));
      end else begin
        check("R5 main rate", mainStrobe, logic'(onTick && (k % m) == 0));
        check("R6 aux rate", auxStrobe, logic'(onTick && (k % a) == 0));
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    // R5 R6 R3 R8: sweep small base divisions against every select pair
    for (int nr = 0; nr <= 5; nr++) begin
      for (int sm = 0; sm < 4; sm++) begin
        for (int sa = 0; sa < 4; sa++) begin
          runCfg(nr, 2'(sm), 2'(sa), ((nr <= 1) ? 1 : nr) * 8 + 3);
        end
      end
    end
    runCfg(7, 2'b01, 2'b10, 60);

    // R2: maximum base division
    runCfg(4095, 2'b00, 2'b10, 8200);

    // R4: base division change mid-interval; ticks at 1,6 then every 3
    startCfg(5, 2'b00, 2'b00);
    for (int p = 1; p <= 18; p++) begin
      bit exp;
      @(posedge clk); #1;
      exp = (p == 1) || (p >= 6 && ((p - 6) % 3) == 0);
      check("R4 main after nr change", mainStrobe, logic'(exp));
      check("R4 aux after nr change", auxStrobe, logic'(exp));
      if (p == 2) begin
        @(negedge clk);
        nrVal = 12'd3;
      end
    end

    // R7: select change mid-cycle; main strobes at 1,9 then every 4
    startCfg(2, 2'b01, 2'b00);
    for (int p = 1; p <= 24; p++) begin
      bit exp;
      @(posedge clk); #1;
      exp = (p == 1) || (p >= 9 && ((p - 9) % 4) == 0);
      check("R7 main after select change", mainStrobe, logic'(exp));
      check("R6 aux unaffected", auxStrobe, logic'((p % 2) == 1));
      if (p == 2) begin
        @(negedge clk);
        mainSel = 2'b10;
      end
    end

    finishRun();
  end

endmodule